// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller with Special Mask Mode

This block gathers eight interrupt request lines, keeps a pending bit for each one, and presents a single interrupt output to a processor. Level 0 has the highest priority and level 7 the lowest. When the processor pulses the acknowledge input, the block reports the index of the winning level. In the same cycle it marks that level as in service and drops its pending bit. Software writes a small command port to load the mask register and to issue end-of-interrupt commands. The same port switches the resolver between two modes.

In nested mode, a level in service holds off itself and every level of lower priority, while higher levels may still interrupt. In special mask mode, an in-service bit holds off only its own level. A running handler can therefore let chosen lower-priority levels through by loading the mask alone, with its own in-service bit still set.

Top module: `pic_core`

## Requirements
- R1: On a cycle with `rst` high, the mask, pending and in-service bits all clear and the block enters nested mode. After reset, `int_out` and `grant_valid` are 0.
- R2: A 0-to-1 change on `irq_in[i]` between two clock edges latches pending bit i. A line that is held high latches nothing more after its bit has been cleared.
- R3: When several levels are eligible, the one with the smallest index is granted.
- R4: With `ack` high and `int_out` high, `grant_valid` is 1 and `grant_idx` holds the granted index in that same cycle. At the next edge that level's in-service bit sets and its pending bit clears.
- R5: In nested mode, an in-service bit at level k blocks levels k through 7, while levels below k may still be granted.
- R6: Writing command 0 loads `wr_data` into the mask register. A set mask bit i keeps level i from being granted. A request that stays pending is granted once its mask bit is cleared.
- R7: In special mask mode, every unmasked pending level whose own in-service bit is clear is eligible, whether it is above or below a level in service.
- R8: A level whose in-service bit is set is never granted, in either mode.
- R9: Command 1 (non-specific end of interrupt) clears the set in-service bit with the smallest index.
- R10: Command 2 (specific end of interrupt) clears in-service bit `wr_data[2:0]` only.
- R11: Command 3 enters special mask mode and command 4 returns to nested mode. Other command codes have no effect.
- R12: An `ack` pulse while `int_out` is 0 gives `grant_valid` 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Request lines, one per level, rising-edge sensitive |
| wr_en | input | 1 | Command write strobe |
| wr_cmd | input | 3 | Command code (0 mask, 1 non-specific EOI, 2 specific EOI, 3 enter special mask, 4 leave special mask) |
| wr_data | input | 8 | Mask value, or the level index in bits 2:0 |
| ack | input | 1 | Acknowledge pulse from the processor |
| int_out | output | 1 | High while any level is eligible |
| grant_valid | output | 1 | High in an acknowledge cycle that grants a level |
| grant_idx | output | 3 | Granted level index, 0 when no level is granted |

## Verification
Single requests are applied first, to show edge latching and index reporting apart from any priority effect. Two simultaneous requests, followed by a higher one that arrives while a lower one is in service, separate fixed priority from nesting. A mask-then-unmask pattern separates masking from losing the request. With level 0 in service, a lower request is raised once in special mask mode and once after returning to nested mode. The opposite outcomes of those two runs show that the mode bit alone decides the blocking. Mixed end-of-interrupt commands show that the non-specific form picks the highest level in service and the specific form touches only its own level.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int NLVL  = 8;
    localparam int IDX_W = $clog2(NLVL);
    localparam int CMD_W = 3;

    typedef logic [NLVL-1:0]  lvl_vec_t;
    typedef logic [IDX_W-1:0] lvl_idx_t;

    typedef enum logic [CMD_W-1:0] {
        CMD_MASK_LOAD = 3'd0,
        CMD_EOI_TOP   = 3'd1,
        CMD_EOI_LEVEL = 3'd2,
        CMD_SMM_ENTER = 3'd3,
        CMD_SMM_LEAVE = 3'd4
    } cmd_e;

    typedef struct packed {
        logic     valid;
        lvl_idx_t idx;
    } pick_t;

    // Lowest set index wins; bit 0 is the most urgent level.
    function automatic pick_t pick_first(lvl_vec_t v);
        pick_t r;
        r = '0;
        for (int i = NLVL - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.valid = 1'b1;
                r.idx   = lvl_idx_t'(i);
            end
        end
        return r;
    endfunction

    function automatic lvl_vec_t one_hot(lvl_idx_t idx);
        lvl_vec_t m;
        for (int i = 0; i < NLVL; i++) m[i] = (i == int'(idx));
        return m;
    endfunction

    // Bits 0..idx set: the levels at or above a given priority.
    function automatic lvl_vec_t upto_mask(lvl_idx_t idx);
        lvl_vec_t m;
        for (int i = 0; i < NLVL; i++) m[i] = (i <= int'(idx));
        return m;
    endfunction

endpackage

// File: rtl/pic_edge_latch.sv
module pic_edge_latch
    import pic_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lvl_vec_t irq_in,
    input  lvl_vec_t clr_vec,
    output lvl_vec_t req_q
);
    lvl_vec_t prev_q;
    lvl_vec_t rise;

    assign rise = irq_in & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            req_q  <= '0;
        end else begin
            prev_q <= irq_in;
            req_q  <= (req_q & ~clr_vec) | rise;
        end
    end

    // R2
    edge_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_in[0] && !prev_q[0]) |=> req_q[0]);

endmodule

// File: rtl/pic_resolver.sv
module pic_resolver
    import pic_pkg::*;
(
    input  lvl_vec_t req,
    input  lvl_vec_t imr,
    input  lvl_vec_t isr,
    input  logic     smm,
    output lvl_vec_t eligible,
    output pick_t    pick
);
    lvl_vec_t chain;
    lvl_vec_t blocked;

    // chain[i]: some level at or above i is in service
    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < NLVL; i++) begin
            acc      = acc | isr[i];
            chain[i] = acc;
        end
    end

    for (genvar g = 0; g < NLVL; g++) begin : g_blk
        assign blocked[g] = smm ? isr[g] : chain[g];
    end

    assign eligible = req & ~imr & ~blocked;
    assign pick     = pick_first(eligible);

endmodule

// File: rtl/pic_ctrl_regs.sv
module pic_ctrl_regs
    import pic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CMD_W-1:0] wr_cmd,
    input  lvl_vec_t         wr_data,
    input  lvl_vec_t         ack_set,
    output lvl_vec_t         imr_q,
    output lvl_vec_t         isr_q,
    output logic             smm_q
);
    cmd_e     cmd;
    lvl_vec_t eoi_clr;
    pick_t    top_isr;
    lvl_idx_t lvl_sel;

    assign cmd     = cmd_e'(wr_cmd);
    assign top_isr = pick_first(isr_q);
    assign lvl_sel = wr_data[IDX_W-1:0];

    always_comb begin
        eoi_clr = '0;
        if (wr_en) begin
            case (cmd)
                CMD_EOI_TOP:   eoi_clr = top_isr.valid ? one_hot(top_isr.idx) : '0;
                CMD_EOI_LEVEL: eoi_clr = one_hot(lvl_sel);
                default:       eoi_clr = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            imr_q <= '0;
            isr_q <= '0;
            smm_q <= 1'b0;
        end else begin
            isr_q <= (isr_q & ~eoi_clr) | ack_set;
            if (wr_en) begin
                case (cmd)
                    CMD_MASK_LOAD: imr_q <= wr_data;
                    CMD_SMM_ENTER: smm_q <= 1'b1;
                    CMD_SMM_LEAVE: smm_q <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    // R10
    eoi_level_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cmd == CMD_EOI_LEVEL && ack_set == '0) |=> !isr_q[$past(lvl_sel)]);

    // R9
    eoi_top_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cmd == CMD_EOI_TOP && ack_set == '0 && isr_q[0]) |=> !isr_q[0]);

endmodule

// File: rtl/pic_core.sv
module pic_core
    import pic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NLVL-1:0]  irq_in,
    input  logic             wr_en,
    input  logic [CMD_W-1:0] wr_cmd,
    input  logic [NLVL-1:0]  wr_data,
    input  logic             ack,
    output logic             int_out,
    output logic             grant_valid,
    output logic [IDX_W-1:0] grant_idx
);
    lvl_vec_t req_q;
    lvl_vec_t imr_q;
    lvl_vec_t isr_q;
    logic     smm_q;
    lvl_vec_t eligible;
    pick_t    pick;
    lvl_vec_t ack_set;

    pic_edge_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .irq_in  (irq_in),
        .clr_vec (ack_set),
        .req_q   (req_q)
    );

    pic_resolver u_res (
        .req      (req_q),
        .imr      (imr_q),
        .isr      (isr_q),
        .smm      (smm_q),
        .eligible (eligible),
        .pick     (pick)
    );

    pic_ctrl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_cmd  (wr_cmd),
        .wr_data (wr_data),
        .ack_set (ack_set),
        .imr_q   (imr_q),
        .isr_q   (isr_q),
        .smm_q   (smm_q)
    );

    assign int_out     = pick.valid;
    assign grant_valid = ack && pick.valid;
    assign grant_idx   = grant_valid ? pick.idx : '0;
    assign ack_set     = grant_valid ? one_hot(pick.idx) : '0;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!int_out && isr_q == '0 && imr_q == '0 && !smm_q));

    // R4
    grant_marks_chk: assert property (@(posedge clk) disable iff (rst)
        grant_valid |=> isr_q[$past(grant_idx)]);

    // R8
    no_regrant_chk: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> !isr_q[grant_idx]);

    // R6
    masked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> !imr_q[grant_idx]);

    // R5
    nest_block_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && !smm_q) |-> ((isr_q & upto_mask(grant_idx)) == '0));

    // R12
    idle_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && eligible == '0) |-> !grant_valid);

endmodule

// File: tb/sim_pic_core.sv
`timescale 1ns/1ps
module sim_pic_core;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] irq;
    logic       wr_en;
    logic [2:0] wr_cmd;
    logic [7:0] wr_data;
    logic       ack;
    logic       int_out;
    logic       grant_valid;
    logic [2:0] grant_idx;

    always #2.5 clk = ~clk;

    pic_core u0 (
        .clk(clk), .rst(rst), .irq_in(irq), .wr_en(wr_en), .wr_cmd(wr_cmd),
        .wr_data(wr_data), .ack(ack), .int_out(int_out),
        .grant_valid(grant_valid), .grant_idx(grant_idx)
    );

    int n_run  = 0;
    int n_fail = 0;
    string cur_req = "R1";
    bit finished = 0;

    // reference state
    bit m_pend [8];
    bit m_mask [8];
    bit m_isv  [8];
    bit m_prev [8];
    bit m_smm;

    int obs_int, obs_gv, obs_idx;

    task automatic chk(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            m_pend[i] = 0; m_mask[i] = 0; m_isv[i] = 0; m_prev[i] = 0;
        end
        m_smm = 0;
    endtask

    task automatic step(input logic [7:0] irqv, input bit we, input int c,
                        input int d, input bit a);
        int win;
        int e_int, e_gv, e_idx;
        int top;
        irq = irqv; wr_en = we; wr_cmd = 3'(c); wr_data = 8'(d); ack = a;
        #1;
        win = -1;
        for (int i = 7; i >= 0; i--) begin
            bit blk;
            blk = 0;
            if (m_smm) blk = m_isv[i];
            else for (int j = 0; j <= i; j++) if (m_isv[j]) blk = 1;
            if (m_pend[i] && !m_mask[i] && !blk) win = i;
        end
        e_int = (win >= 0);
        e_gv  = (a && win >= 0);
        e_idx = e_gv ? win : 0;
        obs_int = int'(int_out); obs_gv = int'(grant_valid); obs_idx = int'(grant_idx);
        chk(obs_int == e_int, {cur_req, " int_out"}, obs_int, e_int);
        chk(obs_gv == e_gv && obs_idx == e_idx, {cur_req, " grant"},
            obs_gv * 8 + obs_idx, e_gv * 8 + e_idx);
        @(posedge clk);
        top = -1;
        for (int i = 7; i >= 0; i--) if (m_isv[i]) top = i;
        if (we && c == 1 && top >= 0) m_isv[top] = 0;
        if (we && c == 2) m_isv[d % 8] = 0;
        if (we && c == 0) for (int i = 0; i < 8; i++) m_mask[i] = d[i];
        if (we && c == 3) m_smm = 1;
        if (we && c == 4) m_smm = 0;
        if (e_gv) begin m_isv[win] = 1; m_pend[win] = 0; end
        for (int i = 0; i < 8; i++) begin
            if (irqv[i] && !m_prev[i]) m_pend[i] = 1;
            m_prev[i] = irqv[i];
        end
        @(negedge clk);
    endtask

    task automatic st(input logic [7:0] v);  step(v, 0, 0, 0, 0); endtask
    task automatic sa(input logic [7:0] v);  step(v, 0, 0, 0, 1); endtask
    task automatic sc(input logic [7:0] v, input int c, input int d); step(v, 1, c, d, 0); endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; irq = 0; wr_en = 0; wr_cmd = 0; wr_data = 0; ack = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        cur_req = "R1";
        st(8'h00); chk(obs_int == 0, "R1 int_out after reset", obs_int, 0);
        sa(8'h00); chk(obs_gv == 0, "R1 no grant after reset", obs_gv, 0);

        cur_req = "R2";
        st(8'h20); st(8'h20); chk(obs_int == 1, "R2 rise latched", obs_int, 1);
        cur_req = "R4";
        sa(8'h20); chk(obs_gv == 1 && obs_idx == 5, "R4 grant index 5", obs_idx, 5);
        cur_req = "R8";
        st(8'h20); chk(obs_int == 0, "R8 in-service level quiet", obs_int, 0);
        cur_req = "R2";
        sc(8'h20, 2, 5); st(8'h20);
        chk(obs_int == 0, "R2 held line no relatch", obs_int, 0);
        st(8'h00);

        cur_req = "R3";
        st(8'h48); sa(8'h48); chk(obs_idx == 3, "R3 lower index wins", obs_idx, 3);
        cur_req = "R5";
        st(8'h48); chk(obs_int == 0, "R5 level 6 blocked by 3", obs_int, 0);
        st(8'h4A); st(8'h4A); chk(obs_int == 1, "R5 level 1 nests", obs_int, 1);
        sa(8'h4A); chk(obs_idx == 1, "R5 nested grant 1", obs_idx, 1);
        cur_req = "R9";
        sc(8'h4A, 1, 0); st(8'h4A);
        chk(obs_int == 0, "R9 cleared 1 only, 3 still blocks", obs_int, 0);
        sc(8'h4A, 1, 0); st(8'h4A); chk(obs_int == 1, "R9 cleared 3", obs_int, 1);
        sa(8'h4A); chk(obs_idx == 6, "R9 then grant 6", obs_idx, 6);
        sc(8'h00, 1, 0); st(8'h00);

        cur_req = "R6";
        sc(8'h00, 0, 8'h04); st(8'h04); st(8'h04);
        chk(obs_int == 0, "R6 masked level held", obs_int, 0);
        sc(8'h04, 0, 8'h00); st(8'h04); chk(obs_int == 1, "R6 unmask releases", obs_int, 1);
        sa(8'h04); chk(obs_idx == 2, "R6 grant 2", obs_idx, 2);
        sc(8'h00, 2, 2); st(8'h00);

        cur_req = "R7";
        st(8'h01); sa(8'h01); chk(obs_idx == 0, "R7 setup grant 0", obs_idx, 0);
        sc(8'h01, 3, 0); st(8'h11); st(8'h11);
        chk(obs_int == 1, "R7 lower level allowed", obs_int, 1);
        sa(8'h11); chk(obs_idx == 4, "R7 grant 4 under 0", obs_idx, 4);
        cur_req = "R8";
        st(8'h10); st(8'h11); st(8'h11);
        chk(obs_int == 0, "R8 level 0 pending but in service", obs_int, 0);
        cur_req = "R11";
        sc(8'h11, 7, 0); st(8'h11);
        chk(obs_int == 0, "R11 unused code no effect", obs_int, 0);
        sc(8'h11, 4, 0); st(8'h31); st(8'h31);
        chk(obs_int == 0, "R11 nested mode blocks 5", obs_int, 0);
        cur_req = "R10";
        sc(8'h31, 2, 0); st(8'h31); chk(obs_int == 1, "R10 level 0 freed", obs_int, 1);
        sa(8'h31); chk(obs_idx == 0, "R10 regrant 0", obs_idx, 0);
        sc(8'h31, 2, 0); st(8'h31);
        chk(obs_int == 0, "R10 level 4 untouched", obs_int, 0);
        sc(8'h31, 2, 4); st(8'h31); chk(obs_int == 1, "R10 level 4 freed", obs_int, 1);
        sa(8'h31); chk(obs_idx == 5, "R10 grant 5", obs_idx, 5);
        sc(8'h00, 1, 0); st(8'h00);

        cur_req = "R12";
        st(8'h00); sa(8'h00); chk(obs_gv == 0, "R12 idle ack", obs_gv, 0);
        st(8'h00); chk(obs_int == 0, "R12 nothing changed", obs_int, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule